// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for each beat of a read or write burst in a double-data-rate DRAM controller or memory model. A column command is presented for one cycle through a start pulse together with the 8-bit starting column, a burst length code and a wrap selector. Starting in the next cycle, the block presents one column address per clock with a valid flag. On the final beat of a fixed-length burst it also raises a last-beat flag.

Fixed bursts of 2, 4 or 8 beats stay inside the aligned block of that size. The low address bits advance by addition (sequential) or by XOR with the beat number (interleaved). Full-page mode has no natural end: it walks through the 256-column page, wraps from the top column back to 0, and runs until a stop pulse or a new column command arrives. A new command may be issued in any cycle, including the cycle right after the previous one, and it restarts the sequence at once.

Top module: `bcg_col_gen`

## Requirements
- R1: While reset is low, and whenever no burst is running, `valid_o`, `last_o` and `col_o` are all 0.
- R2: A cycle with `start_i` high makes the next cycle show `valid_o`=1 and `col_o` equal to the `start_col_i` value presented with the pulse.
- R3: With `bl_code_i` 1, 2 or 3 (2, 4 or 8 beats, N = 2^code) and `wrap_il_i`=0, beat k shows `col_o` = (start with its low log2(N) bits cleared) + ((start + k) mod N).
- R4: With `wrap_il_i`=1 and a fixed length, beat k shows `col_o` = (start with its low log2(N) bits cleared) + ((start mod N) XOR k).
- R5: During a fixed-length burst, the bits of `col_o` above the low log2(N) bits equal those of the start column on every beat.
- R6: `last_o` is high on beat N-1 only. In the cycle after it, `valid_o` is 0 unless a new start arrived.
- R7: With `bl_code_i`=0 (full page), beat k shows (start + k) mod 256. `last_o` never rises, and the burst continues until stopped or restarted.
- R8: Full page with `wrap_il_i`=1 produces exactly the sequential full-page order.
- R9: A cycle with `stop_i` high and `start_i` low makes `valid_o` 0 in the next cycle. A stop while idle has no effect.
- R10: A start during a running burst restarts the sequence at the new column from beat 0. When start and stop arrive in the same cycle, the start wins.
- R11: A start presented in the cycle of a last beat produces a gapless following burst, with `valid_o` staying high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Column command pulse |
| stop_i | input | 1 | Burst stop pulse |
| start_col_i | input | 8 | Starting column |
| bl_code_i | input | 2 | 0 full page, 1/2/3 for 2/4/8 beats |
| wrap_il_i | input | 1 | 1 interleaved, 0 sequential |
| col_o | output | 8 | Current column address |
| valid_o | output | 1 | Beat address valid |
| last_o | output | 1 | Final beat of fixed burst |

## Verification
Two events can share a cycle: a new column command can land on the last beat of a burst, or on the same cycle as a stop pulse. Directed cases force each pairing: back-to-back 2-beat bursts, and a start together with a stop in the middle of an 8-beat burst. A random phase then issues starts and stops freely across all modes. A cycle-level bench model predicts, for every cycle, whether a burst runs, which beat it is on and which column it shows. The comparison confirms that the new command takes over with no idle gap and that the stop is dropped.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [1:0] {
    BL_PAGE = 2'd0,
    BL_TWO  = 2'd1,
    BL_FOUR = 2'd2,
    BL_EIGHT = 2'd3
  } bl_code_e;
endpackage

// File: rtl/bcg_addr_calc.sv
module bcg_addr_calc #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_col_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [1:0]       bl_code_i,
  input  logic             il_i,
  output logic [COL_W-1:0] mask_o,
  output logic [COL_W-1:0] col_o
);
  import bcg_pkg::*;

  // Mask of the bits that move within the burst; all ones for full page.
  function automatic logic [COL_W-1:0] wrap_mask(input logic [1:0] code);
    if (code == BL_PAGE) return '1;
    return (COL_W'(1) << code) - COL_W'(1);
  endfunction

  // Column of a beat: upper bits frozen, lower bits add or XOR.
  function automatic logic [COL_W-1:0] beat_col(input logic [COL_W-1:0] base,
                                                input logic [COL_W-1:0] beat,
                                                input logic [COL_W-1:0] m,
                                                input logic xor_mode);
    logic [COL_W-1:0] moved;
    moved = xor_mode ? (base ^ beat) : (base + beat);
    return (base & ~m) | (moved & m);
  endfunction

  logic il_eff;
  assign il_eff = il_i && (bl_code_i != BL_PAGE);
  assign mask_o = wrap_mask(bl_code_i);
  assign col_o  = beat_col(base_col_i, beat_i, mask_o, il_eff);
endmodule

// File: rtl/bcg_beat_ctr.sv
module bcg_beat_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             abort_i,
  input  logic             fixed_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             active_o,
  output logic [CNT_W-1:0] beat_o,
  output logic             last_o
);
  logic             active_q;
  logic [CNT_W-1:0] beat_q;

  assign last_o = active_q && fixed_i && (beat_q == limit_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
    end else if (abort_i) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (active_q) begin
      if (last_o) begin
        active_q <= 1'b0;
        beat_q   <= '0;
      end else begin
        beat_q <= beat_q + CNT_W'(1);
      end
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;

  AST_BEAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && fixed_i) |-> (beat_q <= limit_i)); // R6

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !load_i) |=> !active_q); // R6
endmodule

// File: rtl/bcg_col_gen.sv
module bcg_col_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       bl_code_i,
  input  logic             wrap_il_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  import bcg_pkg::*;

  logic [COL_W-1:0] base_q;
  logic [1:0]       code_q;
  logic             il_q;

  // Named events for the checks
  logic ev_load, ev_abort, ev_page;
  logic [COL_W-1:0] mask, beat, addr;
  logic active, last_beat;

  assign ev_load  = start_i;
  assign ev_abort = stop_i && !start_i;
  assign ev_page  = (code_q == BL_PAGE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      code_q <= BL_TWO;
      il_q   <= 1'b0;
    end else if (ev_load) begin
      base_q <= start_col_i;
      code_q <= bl_code_i;
      il_q   <= wrap_il_i;
    end
  end

  bcg_beat_ctr #(.CNT_W(COL_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (ev_load),
    .abort_i  (ev_abort),
    .fixed_i  (!ev_page),
    .limit_i  (mask),
    .active_o (active),
    .beat_o   (beat),
    .last_o   (last_beat)
  );

  bcg_addr_calc #(.COL_W(COL_W)) u_addr (
    .base_col_i (base_q),
    .beat_i     (beat),
    .bl_code_i  (code_q),
    .il_i       (il_q),
    .mask_o     (mask),
    .col_o      (addr)
  );

  assign valid_o = active;
  assign last_o  = last_beat;
  assign col_o   = active ? addr : '0;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (col_o == '0 && !last_o)); // R1

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(start_col_i))); // R2

  AST_HIGH_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !start_i && !stop_i && !last_o && !ev_page)
      |=> ((col_o & ~mask) == ($past(col_o) & ~mask))); // R5

  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ev_page) |-> !last_o); // R7

  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ev_page && !start_i && !stop_i)
      |=> (valid_o && col_o == ($past(col_o) + COL_W'(1)))); // R7

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> !valid_o); // R9
endmodule

// File: tb/test_bcg_col_gen.sv
module test_bcg_col_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, wrap_il_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [1:0] bl_code_i = '0;
  logic [7:0] col_o;
  logic valid_o, last_o;

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";
  bit started = 0;

  // Bench model state
  bit m_act = 0;
  logic [7:0] m_st = '0, m_k = '0;
  logic [1:0] m_bl = '0;
  bit m_il = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcg_col_gen i_bcg_col_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .start_col_i(start_col_i), .bl_code_i(bl_code_i), .wrap_il_i(wrap_il_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  function automatic int beats(input logic [1:0] b);
    return (b == 2'd0) ? 256 : (2 ** b);
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] st, input logic [1:0] b,
                                         input bit il, input logic [7:0] k);
    int n, base, off;
    if (b == 2'd0) return 8'((int'(st) + int'(k)) % 256);
    n = beats(b);
    base = (int'(st) / n) * n;
    if (il) off = (int'(st) % n) ^ int'(k);
    else    off = (int'(st) % n + int'(k)) % n;
    return 8'(base + off);
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (!rst_n) begin
      m_act <= 0; m_k <= '0;
    end else if (start_i) begin
      m_act <= 1; m_k <= '0; m_st <= start_col_i; m_bl <= bl_code_i; m_il <= wrap_il_i;
    end else if (stop_i) begin
      m_act <= 0;
    end else if (m_act) begin
      if (m_bl != 2'd0 && int'(m_k) == beats(m_bl) - 1) m_act <= 0;
      else m_k <= m_k + 8'd1;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      logic [7:0] ec;
      bit el;
      string t;
      ec = m_act ? exp_col(m_st, m_bl, m_il, m_k) : 8'd0;
      el = m_act && (m_bl != 2'd0) && (int'(m_k) == beats(m_bl) - 1);
      t = tag;
      if (t == "") t = !m_act ? "R9" : (m_bl == 2'd0) ? (m_il ? "R8" : "R7") : (m_il ? "R4" : "R3");
      checks++;
      if (col_o !== ec || valid_o !== m_act || last_o !== el) begin
        fails++;
        $display("FAIL %s: col=%02h valid=%0b last=%0b expected col=%02h valid=%0b last=%0b",
                 t, col_o, valid_o, last_o, ec, m_act, el);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic cyc(input bit s, input bit p, input logic [7:0] c,
                     input logic [1:0] b, input bit il);
    start_i = s; stop_i = p; start_col_i = c; bl_code_i = b; wrap_il_i = il;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 2'd0, 0);
  endtask

  initial begin
    void'($urandom(32'd4021));
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    tag = "R2"; cyc(1, 0, 8'hA6, 2'd1, 0); idle(3);
    tag = "R3"; cyc(1, 0, 8'hFD, 2'd2, 0); idle(5);
    tag = "R4"; cyc(1, 0, 8'hFD, 2'd2, 1); idle(5);
    cyc(1, 0, 8'h35, 2'd3, 1); idle(9);
    tag = "R5"; cyc(1, 0, 8'h7F, 2'd1, 0); idle(3);
    cyc(1, 0, 8'h7F, 2'd3, 1); idle(9);
    tag = "R6"; cyc(1, 0, 8'h12, 2'd3, 0); idle(10);
    tag = "R7"; cyc(1, 0, 8'hFE, 2'd0, 0); idle(300);
    cyc(0, 1, 8'h00, 2'd0, 0); idle(2);
    tag = "R8"; cyc(1, 0, 8'h10, 2'd0, 1); idle(6);
    cyc(0, 1, 8'h00, 2'd0, 0); idle(2);
    tag = "R9"; cyc(1, 0, 8'h40, 2'd3, 0); idle(2);
    cyc(0, 1, 8'h00, 2'd0, 0); idle(2);
    cyc(0, 1, 8'h00, 2'd0, 0); idle(2);
    tag = "R10"; cyc(1, 0, 8'h20, 2'd3, 0); idle(2);
    cyc(1, 1, 8'h9B, 2'd2, 1); idle(2);
    cyc(1, 0, 8'h55, 2'd3, 1); idle(10);
    tag = "R11";
    for (int i = 0; i < 6; i++) begin
      cyc(1, 0, 8'(8'h30 + i * 7), 2'd1, 1'(i % 2));
      idle(1);
    end
    cyc(1, 0, 8'hC3, 2'd2, 0); idle(3);
    cyc(1, 0, 8'hE1, 2'd2, 1); idle(5);
    tag = "";
    for (int i = 0; i < 4000; i++) begin
      bit s, p;
      s = ($urandom % 6) == 0;
      p = ($urandom % 25) == 0;
      cyc(s, p, 8'($urandom), 2'($urandom), 1'($urandom));
    end
    idle(5);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule